// File: doc/BRIEF.md
# Predicate Shadow Modifier Unit

This block governs a run of instructions that follow a predication modifier. The modifier names three predicate sources, called A, B and C. Each source has its own register value, its own bit index and its own invert flag. The modifier also carries one 2-bit condition code for each of the instructions it governs. When the modifier issues, the unit reads the three chosen bits, applies the inversions and latches the results. For each governed instruction that issues later, the unit decides whether it executes or is suppressed.

The slot codes map to conditions as follows:

| Code | Condition |
|------|-----------|
| `00` | Always execute |
| `01` | Execute if latched bit A is 1 |
| `10` | Execute if latched bit B is 1 |
| `11` | Execute if latched bit C is 1 |

Any source may carry the same register value as another, so a pair such as A and inverted A gives the familiar execute-if-true and execute-if-false predication. The register file reads arrive as plain input values.

The shadow ends in one of three ways:
- the last slot is used;
- a new modifier issues and replaces it;
- a flush clears it, for example on a taken branch.

Outside a shadow every instruction executes.

Top module: `pred_shadow_unit`

## Requirements
- R1: After reset no shadow is active, and the next issuing instruction executes.
- R2: While no shadow is active, every issuing instruction executes (`ins_exec`=1, `ins_suppress`=0).
- R3: A slot whose code is `00` executes whatever the latched bits are.
- R4: The slot codes select the condition. Code `01` executes if and only if latched bit A is 1, code `10` uses bit B, and code `11` uses bit C. Slot k is held in `mod_slots[2k+1:2k]`, and slot 0 governs the first instruction that issues after the modifier.
- R5: `mod_inv[0]` inverts source A, `mod_inv[1]` inverts source B and `mod_inv[2]` inverts source C, before the bit is latched.
- R6: Each bit index (`mod_idx_a/b/c`, 0..XLEN-1) selects which bit of the matching register value becomes the predicate.
- R7: The predicate bits are sampled in the cycle the modifier issues. Changes to `rd_a/b/c` after that cycle do not affect the current shadow.
- R8: The slot pointer advances only on cycles with `ins_issue`=1. A suppressed instruction still uses its slot, and idle cycles use none.
- R9: After the SLOTS-th governed instruction the shadow ends: `shadow_active` is 0 from the next cycle, and later instructions execute.
- R10: A modifier that issues while a shadow is active replaces it. The next instruction uses slot 0 of the new modifier with its newly latched bits.
- R11: A flush clears the shadow, so `shadow_active` is 0 from the next cycle. If a flush and a modifier arrive in the same cycle, the flush wins and no shadow starts.
- R12: With `ins_issue`=0, both `ins_exec` and `ins_suppress` are 0. With `ins_issue`=1, exactly one of them is 1. The decision is based on the shadow present at the start of that cycle.
- R13: Two sources may carry the same register value. Source A and inverted source B on the same bit then give opposite conditions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Clears the active shadow |
| mod_issue | input | 1 | A predication modifier issues this cycle |
| mod_slots | input | 2*SLOTS | Slot condition codes; slot k sits at [2k+1:2k] |
| mod_inv | input | 3 | Invert flags for sources A (bit 0), B (bit 1) and C (bit 2) |
| mod_idx_a | input | $clog2(XLEN) | Bit index for source A |
| mod_idx_b | input | $clog2(XLEN) | Bit index for source B |
| mod_idx_c | input | $clog2(XLEN) | Bit index for source C |
| rd_a | input | XLEN | Register value for source A |
| rd_b | input | XLEN | Register value for source B |
| rd_c | input | XLEN | Register value for source C |
| ins_issue | input | 1 | A governed instruction issues this cycle |
| ins_exec | output | 1 | The issuing instruction executes |
| ins_suppress | output | 1 | The issuing instruction is suppressed |
| shadow_active | output | 1 | A shadow is in force |

## Verification
The bench first issues instructions with no shadow, to show the default. It then runs a shadow that mixes all four codes, with idle gaps between issues and a change to the register values after latching. This separates slot selection, pointer advance on issue cycles only, and sampling at issue time. Further shadows check the following:
- shared register values with one source inverted, which tells inversion apart from source choice;
- a bit index near the top of the word, compared against its neighbouring bit;
- a modifier replacing a shadow part way through, which shows a restart at slot 0.

Flushes, both alone and together with a modifier, together with the instruction after the last slot, check each of the ways a shadow ends.

// File: rtl/pred_shadow_unit.sv
module pred_shadow_unit #(
  parameter int XLEN  = 64,
  parameter int SLOTS = 8,
  localparam int IW   = $clog2(XLEN),
  localparam int PW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               mod_issue,
  input  logic [2*SLOTS-1:0] mod_slots,
  input  logic [2:0]         mod_inv,
  input  logic [IW-1:0]      mod_idx_a,
  input  logic [IW-1:0]      mod_idx_b,
  input  logic [IW-1:0]      mod_idx_c,
  input  logic [XLEN-1:0]    rd_a,
  input  logic [XLEN-1:0]    rd_b,
  input  logic [XLEN-1:0]    rd_c,
  input  logic               ins_issue,
  output logic               ins_exec,
  output logic               ins_suppress,
  output logic               shadow_active
);

  logic               act_q;
  logic [PW-1:0]      ptr_q;
  logic [2*SLOTS-1:0] codes_q;
  logic [2:0]         pbit_q;
  logic [1:0]         cur_code;
  logic               cond;
  logic               last_slot;

  assign cur_code  = codes_q[2*ptr_q +: 2];
  assign last_slot = (ptr_q == PW'(SLOTS-1));

  always_comb begin
    case (cur_code)
      2'b00:   cond = 1'b1;
      2'b01:   cond = pbit_q[0];
      2'b10:   cond = pbit_q[1];
      default: cond = pbit_q[2];
    endcase
  end

  assign ins_suppress  = ins_issue & act_q & ~cond;
  assign ins_exec      = ins_issue & ~ins_suppress;
  assign shadow_active = act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      ptr_q   <= '0;
      codes_q <= '0;
      pbit_q  <= '0;
    end else if (flush) begin
      act_q <= 1'b0;
      ptr_q <= '0;
    end else if (mod_issue) begin
      act_q   <= 1'b1;
      ptr_q   <= '0;
      codes_q <= mod_slots;
      pbit_q  <= {rd_c[mod_idx_c] ^ mod_inv[2],
                  rd_b[mod_idx_b] ^ mod_inv[1],
                  rd_a[mod_idx_a] ^ mod_inv[0]};
    end else if (ins_issue && act_q) begin
      if (last_slot) begin
        act_q <= 1'b0;
        ptr_q <= '0;
      end else begin
        ptr_q <= ptr_q + 1'b1;
      end
    end
  end

  AST_ONE_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
    ins_issue |-> (ins_exec ^ ins_suppress)); // R12
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_issue |-> (!ins_exec && !ins_suppress)); // R12
  AST_NO_SHADOW_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_issue && !shadow_active) |-> ins_exec); // R2
  AST_CODE_ZERO_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_issue && act_q && cur_code == 2'b00) |-> ins_exec); // R3
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !shadow_active); // R11
  AST_MOD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_issue && !flush) |=> (shadow_active && ptr_q == '0)); // R10
  AST_PTR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !ins_issue && !mod_issue && !flush) |=> ($stable(ptr_q) && shadow_active)); // R8
  AST_BITS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mod_issue) |=> $stable(pbit_q)); // R7
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && last_slot && ins_issue && !mod_issue && !flush) |=> !shadow_active); // R9

endmodule

// File: tb/pred_shadow_unit_test.sv
module pred_shadow_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN  = 64;
  localparam int SLOTS = 8;
  localparam int IW    = $clog2(XLEN);

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               flush = 1'b0;
  logic               mod_issue = 1'b0;
  logic [2*SLOTS-1:0] mod_slots = '0;
  logic [2:0]         mod_inv = '0;
  logic [IW-1:0]      mod_idx_a = '0, mod_idx_b = '0, mod_idx_c = '0;
  logic [XLEN-1:0]    rd_a = '0, rd_b = '0, rd_c = '0;
  logic               ins_issue = 1'b0;
  logic               ins_exec, ins_suppress, shadow_active;

  int errors = 0;
  int checks = 0;
  bit    exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pred_shadow_unit #(.XLEN(XLEN), .SLOTS(SLOTS)) uut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .mod_issue(mod_issue),
    .mod_slots(mod_slots), .mod_inv(mod_inv),
    .mod_idx_a(mod_idx_a), .mod_idx_b(mod_idx_b), .mod_idx_c(mod_idx_c),
    .rd_a(rd_a), .rd_b(rd_b), .rd_c(rd_c), .ins_issue(ins_issue),
    .ins_exec(ins_exec), .ins_suppress(ins_suppress), .shadow_active(shadow_active)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // monitor: compares each issuing instruction against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (ins_issue) begin
        if (exp_q.size() == 0) begin
          chk(1'b1, 1'b0, "R12 unexpected issue");
        end else begin
          bit e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(ins_exec, e, {t, " exec"});
          chk(ins_suppress, ~e, {t, " suppress"});
        end
      end else begin
        chk(ins_exec | ins_suppress, 1'b0, "R12 idle outputs");
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic issue(input bit e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    ins_issue = 1'b1;
    step();
    ins_issue = 1'b0;
  endtask

  task automatic modifier(input logic [2*SLOTS-1:0] s, input logic [2:0] inv,
                          input logic [IW-1:0] ia, input logic [IW-1:0] ib,
                          input logic [IW-1:0] ic);
    mod_issue = 1'b1; mod_slots = s; mod_inv = inv;
    mod_idx_a = ia; mod_idx_b = ib; mod_idx_c = ic;
    step();
    mod_issue = 1'b0;
  endtask

  task automatic do_flush();
    flush = 1'b1;
    step();
    flush = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    chk(shadow_active, 1'b0, "R1 reset shadow");
    issue(1'b1, "R1");
    issue(1'b1, "R2");
    issue(1'b1, "R2");

    // A: bit5=1, B: bit63=0, C: bit0=1; slots 01,10,11,00,10,10,10,10
    rd_a = 64'h20; rd_b = 64'h7FFF_FFFF_FFFF_FFFF; rd_c = 64'h1;
    modifier({2'b10, 2'b10, 2'b10, 2'b10, 2'b00, 2'b11, 2'b10, 2'b01}, 3'b000, 6'd5, 6'd63, 6'd0);
    chk(shadow_active, 1'b1, "R4 shadow starts");
    rd_a = '0; rd_b = '1; rd_c = '0;
    issue(1'b1, "R4 slot0 A");
    step(); step();
    chk(shadow_active, 1'b1, "R8 idle keeps shadow");
    issue(1'b0, "R4 slot1 B");
    issue(1'b1, "R8 slot2 C after suppress");
    issue(1'b1, "R3 slot3 code00");
    issue(1'b0, "R7 slot4 latched B");
    issue(1'b0, "R7 slot5");
    step();
    issue(1'b0, "R8 slot6");
    issue(1'b0, "R9 slot7");
    chk(shadow_active, 1'b0, "R9 shadow ended");
    issue(1'b1, "R9 after last slot");

    // shared value, B inverted; C inverted; slots 01,10,11,01...
    rd_a = 64'h80; rd_b = 64'h80; rd_c = 64'h80;
    modifier({2'b01, 2'b01, 2'b01, 2'b01, 2'b01, 2'b11, 2'b10, 2'b01}, 3'b110, 6'd7, 6'd7, 6'd7);
    issue(1'b1, "R13 A true");
    issue(1'b0, "R13 ~A via B");
    issue(1'b0, "R5 C inverted");

    // replace mid-shadow: slot0=00, slot1=10 (B bit0=0), rest 01 (A=1)
    rd_a = 64'h1; rd_b = 64'h2;
    modifier({2'b01, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01, 2'b10, 2'b00}, 3'b000, 6'd0, 6'd0, 6'd0);
    issue(1'b1, "R10 new slot0");
    issue(1'b0, "R10 new slot1");
    issue(1'b1, "R10 new slot2");
    chk(shadow_active, 1'b1, "R10 shadow still active");

    // flush alone
    rd_b = '0;
    modifier({SLOTS{2'b10}}, 3'b000, 6'd0, 6'd0, 6'd0);
    issue(1'b0, "R11 before flush");
    do_flush();
    chk(shadow_active, 1'b0, "R11 flush clears");
    issue(1'b1, "R11 after flush");

    // flush with modifier: flush wins
    flush = 1'b1;
    modifier({SLOTS{2'b10}}, 3'b000, 6'd0, 6'd0, 6'd0);
    flush = 1'b0;
    chk(shadow_active, 1'b0, "R11 flush beats modifier");
    issue(1'b1, "R11 no shadow");

    // bit index: A idx 40 -> 1, B idx 39 -> 0 on the same value
    rd_a = 64'h1 << 40; rd_b = 64'h1 << 40;
    modifier({2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b10, 2'b01}, 3'b000, 6'd40, 6'd39, 6'd0);
    issue(1'b1, "R6 index 40");
    issue(1'b0, "R6 index 39");
    do_flush();

    step();
    chk(exp_q.size() == 0, 1'b1, "R12 scoreboard drained");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule